// File: doc/BRIEF.md
# Two-Output Regulator Power Sequencer

This block is the digital sequencer for a regulator with two outputs: a synchronous switching stage and a linear pass stage. It does no analog work. Comparators outside the block report supply level, enable pin level, over-current on the low-side switch and under-voltage on each feedback node as single-bit flags. The block turns those flags into enables for both stages, forced-off commands for the two gate drivers, and a one-cycle pulse that starts the soft-start ramp.

The controller has four states: off, soft-start, run and latched fault. Supply validity uses two thresholds. A flag for the rising threshold sets it, and a separate flag for the falling threshold clears it, which gives hysteresis. Both outputs start together, and any protection event stops both together. A latched fault clears only on loss of supply or a low level on the enable pin. After either event the outputs come back through a complete new soft-start.

Top module: `pwr_seq_top`

## Requirements
- R1: Supply validity is set in a cycle where `sup_above_rise` is high and is held after that flag falls. It stays clear until that flag is seen. No output starts while supply is not valid.
- R2: `sup_below_fall` high clears supply validity, and it wins over `sup_above_rise` in the same cycle. At the next edge the block goes to off, with `sw_en`=0, `lin_en`=0, `hs_off`=1 and `ls_off`=1.
- R3: `en_pin` low forces the off state at the next edge: both enables low and both forced-off commands high.
- R4: An over-current trip needs `ocp_trip` and `ls_on` both high in `OCP_PERSIST` (default 2) consecutive cycles while in soft-start or run. A cycle with either flag low restarts the count. `ocp_trip` with `ls_on` low is ignored.
- R5: `uv_sw` and `uv_lin` are ignored during soft-start.
- R6: In run, `uv_sw` or `uv_lin` high moves the block to latched fault at the next edge, with both stages disabled and both gates forced off.
- R7: Latched fault persists while supply stays valid and `en_pin` stays high, whatever the other flags do. Only R2 or R3 leave it.
- R8: From off, with valid supply and `en_pin` high, the block enters soft-start at the next edge. `ss_start` is high for exactly that first soft-start cycle.
- R9: `ss_done` in soft-start moves the block to run at the next edge, and run holds after `ss_done` falls. Every state change takes effect one edge after its input. The priority order is supply loss, then enable low, then fault conditions.
- R10: Asynchronous `rst_n` low immediately gives the off state outputs: `sw_en`=0, `lin_en`=0, `hs_off`=1, `ls_off`=1, `ss_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_rise | input | 1 | Supply is above the rising threshold |
| sup_below_fall | input | 1 | Supply is below the falling threshold |
| en_pin | input | 1 | Enable pin level, high enables |
| ocp_trip | input | 1 | Low-side drop exceeds the over-current limit |
| ls_on | input | 1 | Low-side switch is currently conducting |
| uv_sw | input | 1 | Switching feedback below half of reference |
| uv_lin | input | 1 | Linear feedback below half of reference |
| ss_done | input | 1 | Soft-start ramp has finished |
| sw_en | output | 1 | Switching stage enable |
| lin_en | output | 1 | Linear stage enable |
| hs_off | output | 1 | Force high-side gate off |
| ls_off | output | 1 | Force low-side gate off |
| ss_start | output | 1 | One-cycle soft-start start pulse |

## Verification
The stimulus targets four failure modes:
- **Over-current filter.** It is probed with a single trip, a broken pair, and a trip whose `ls_on` drops in the second cycle. A design that skips the persistence count or the `ls_on` qualification would trip early.
- **Under-voltage during soft-start.** The flags are raised while soft-start is active. A design that arms them too soon would latch off during the ramp.
- **Fault latch.** The latch is held while `sup_above_rise` pulses again. A design that treats the rising flag as a clear would restart.
- **Threshold collision.** A cycle with both supply flags high checks that the falling threshold wins.

A reset in the middle of run checks that the outputs fall without waiting for a clock edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SOFT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_LATCH = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       ss_pulse;
    } seq_reg_t;

endpackage

// File: rtl/pwr_seq_por.sv
module pwr_seq_por (
    input  logic clk,
    input  logic rst_n,
    input  logic above_rise,
    input  logic below_fall,
    output logic supply_ok_d
);
    logic good_d, good_q;

    always_comb begin
        good_d = good_q;
        if (below_fall)
            good_d = 1'b0;
        else if (above_rise)
            good_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            good_q <= 1'b0;
        else
            good_q <= good_d;
    end

    assign supply_ok_d = good_d;
endmodule

// File: rtl/pwr_seq_ocp_filt.sv
module pwr_seq_ocp_filt #(
    parameter int OCP_PERSIST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic ls_on,
    input  logic trip_raw,
    output logic trip_hit
);
    localparam int CW = (OCP_PERSIST < 2) ? 1 : $clog2(OCP_PERSIST + 1);
    localparam logic [CW-1:0] LAST = CW'(OCP_PERSIST - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          sample;

    assign sample   = armed && ls_on && trip_raw;
    assign trip_hit = sample && (cnt_q == LAST);

    always_comb begin
        cnt_d = '0;
        if (sample)
            cnt_d = trip_hit ? cnt_q : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       en_pin,
    input  logic       ocp_hit,
    input  logic       uv_sw,
    input  logic       uv_lin,
    input  logic       ss_done,
    output seq_state_e st,
    output logic       ss_start
);
    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d          = seq_q;
        seq_d.ss_pulse = 1'b0;
        if (!supply_ok) begin
            seq_d.st = ST_OFF;
        end else if (!en_pin) begin
            seq_d.st = ST_OFF;
        end else begin
            case (seq_q.st)
                ST_OFF: begin
                    seq_d.st       = ST_SOFT;
                    seq_d.ss_pulse = 1'b1;
                end
                ST_SOFT: begin
                    if (ocp_hit)
                        seq_d.st = ST_LATCH;
                    else if (ss_done)
                        seq_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (ocp_hit || uv_sw || uv_lin)
                        seq_d.st = ST_LATCH;
                end
                default: seq_d.st = ST_LATCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st       <= ST_OFF;
            seq_q.ss_pulse <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st       = seq_q.st;
    assign ss_start = seq_q.ss_pulse;
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int OCP_PERSIST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_rise,
    input  logic sup_below_fall,
    input  logic en_pin,
    input  logic ocp_trip,
    input  logic ls_on,
    input  logic uv_sw,
    input  logic uv_lin,
    input  logic ss_done,
    output logic sw_en,
    output logic lin_en,
    output logic hs_off,
    output logic ls_off,
    output logic ss_start
);
    logic       supply_ok;
    logic       ocp_hit;
    logic       active;
    seq_state_e st;

    pwr_seq_por u_por (
        .clk         (clk),
        .rst_n       (rst_n),
        .above_rise  (sup_above_rise),
        .below_fall  (sup_below_fall),
        .supply_ok_d (supply_ok)
    );

    pwr_seq_ocp_filt #(.OCP_PERSIST(OCP_PERSIST)) u_ocp (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (active),
        .ls_on    (ls_on),
        .trip_raw (ocp_trip),
        .trip_hit (ocp_hit)
    );

    pwr_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .en_pin    (en_pin),
        .ocp_hit   (ocp_hit),
        .uv_sw     (uv_sw),
        .uv_lin    (uv_lin),
        .ss_done   (ss_done),
        .st        (st),
        .ss_start  (ss_start)
    );

    assign active = (st == ST_SOFT) || (st == ST_RUN);
    assign sw_en  = active;
    assign lin_en = active;
    assign hs_off = !active;
    assign ls_off = !active;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sup_below_fall,
    input logic       en_pin,
    input logic       uv_sw,
    input logic       uv_lin,
    input logic       sw_en,
    input logic       lin_en,
    input logic       hs_off,
    input logic       ls_off,
    input logic       ss_start,
    input seq_state_e st
);
    a_r2_fall_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        sup_below_fall |=> (!sw_en && !lin_en && hs_off && ls_off));

    a_r3_enable_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_pin |=> (hs_off && ls_off && !sw_en && !lin_en));

    a_r6_uv_in_run_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && (uv_sw || uv_lin) && en_pin && !sup_below_fall)
        |=> (!sw_en && !lin_en));

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATCH && en_pin && !sup_below_fall) |=> (st == ST_LATCH));

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |=> !ss_start);

    a_r8_start_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> ss_start);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sup_below_fall (sup_below_fall),
    .en_pin         (en_pin),
    .uv_sw          (uv_sw),
    .uv_lin         (uv_lin),
    .sw_en          (sw_en),
    .lin_en         (lin_en),
    .hs_off         (hs_off),
    .ls_off         (ls_off),
    .ss_start       (ss_start),
    .st             (st)
);

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rise = 1'b0, fall = 1'b0, en = 1'b0, ocp = 1'b0, ls = 1'b0;
    logic uvs = 1'b0, uvl = 1'b0, ssd = 1'b0;
    logic sw_en, lin_en, hs_off, ls_off, ss_start;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    pwr_seq_top u0 (
        .clk(clk), .rst_n(rst_n),
        .sup_above_rise(rise), .sup_below_fall(fall), .en_pin(en),
        .ocp_trip(ocp), .ls_on(ls), .uv_sw(uvs), .uv_lin(uvl), .ss_done(ssd),
        .sw_en(sw_en), .lin_en(lin_en), .hs_off(hs_off), .ls_off(ls_off),
        .ss_start(ss_start)
    );

    // {req, inputs rise fall en ocp ls uvs uvl ssd, expected sw lin hso lso ss}
    localparam logic [16:0] VEC [31] = '{
        {4'd1,  8'b0010_0000, 5'b00110},  // R1 no valid supply yet
        {4'd3,  8'b1000_0000, 5'b00110},  // R3 supply valid, enable low
        {4'd1,  8'b0010_0000, 5'b11001},  // R1 validity held, start
        {4'd5,  8'b0010_0110, 5'b11000},  // R5 uv masked in soft-start
        {4'd4,  8'b0011_0000, 5'b11000},  // R4 trip ignored, ls off
        {4'd4,  8'b0011_1000, 5'b11000},  // R4 first qualified sample
        {4'd4,  8'b0010_1000, 5'b11000},  // R4 broken pair
        {4'd4,  8'b0011_1000, 5'b11000},  // R4 count 1 again
        {4'd4,  8'b0011_0000, 5'b11000},  // R4 ls off restarts count
        {4'd9,  8'b0010_0001, 5'b11000},  // R9 done -> run
        {4'd9,  8'b0010_0000, 5'b11000},  // R9 run holds
        {4'd6,  8'b0010_0010, 5'b00110},  // R6 linear uv trips
        {4'd7,  8'b0010_0000, 5'b00110},  // R7 latched
        {4'd7,  8'b1010_0000, 5'b00110},  // R7 rising flag no clear
        {4'd7,  8'b0000_0000, 5'b00110},  // R7 enable low clears
        {4'd8,  8'b0010_0000, 5'b11001},  // R8 full restart
        {4'd9,  8'b0010_0001, 5'b11000},  // R9 run
        {4'd4,  8'b0011_1000, 5'b11000},  // R4 first sample in run
        {4'd4,  8'b0011_1000, 5'b00110},  // R4 second sample trips
        {4'd2,  8'b0110_0000, 5'b00110},  // R2 supply loss
        {4'd1,  8'b0010_0000, 5'b00110},  // R1 stays off w/o rise
        {4'd8,  8'b1010_0000, 5'b11001},  // R8 start after rise
        {4'd9,  8'b0010_0001, 5'b11000},  // R9 run
        {4'd6,  8'b0010_0100, 5'b00110},  // R6 switching uv trips
        {4'd2,  8'b0100_0000, 5'b00110},  // R2 clears fault
        {4'd2,  8'b1110_0000, 5'b00110},  // R2 fall beats rise
        {4'd1,  8'b1010_0000, 5'b11001},  // R1 rise starts
        {4'd4,  8'b0011_1000, 5'b11000},  // R4 sample 1 in soft-start
        {4'd4,  8'b0011_1000, 5'b00110},  // R4 trip in soft-start
        {4'd7,  8'b0010_0000, 5'b00110},  // R7 held
        {4'd2,  8'b0100_0000, 5'b00110}   // R2 off
    };

    task automatic check(input int req, input logic [4:0] exp);
        logic [4:0] act;
        act = {sw_en, lin_en, hs_off, ls_off, ss_start};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] v);
        {rise, fall, en, ocp, ls, uvs, uvl, ssd} = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1;
        check(10, 5'b00110);  // R10 reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(10, 5'b00110);  // R10 after release, no edge yet
        for (int i = 0; i < 31; i++) begin
            apply(VEC[i][12:5]);
            check(int'(VEC[i][16:13]), VEC[i][4:0]);
        end
        // R9: ss_done while off does not skip soft-start
        apply(8'b1010_0001);
        check(9, 5'b11001);
        apply(8'b0010_0001);
        check(9, 5'b11000);
        // R3: enable low and uv same cycle in run -> off
        apply(8'b0000_0110);
        check(3, 5'b00110);
        apply(8'b0010_0000);
        check(8, 5'b11001);
        apply(8'b0010_0001);
        check(9, 5'b11000);
        // R10: asynchronous reset in run
        #1 rst_n = 1'b0;
        #0.5 check(10, 5'b00110);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'b0010_0000);  // R1 validity lost by reset
        check(1, 5'b00110);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule